// File: doc/BRIEF.md
# Multi-Stream Line Prefetch Engine

This block sits beside a shared second-level cache with 32-byte lines and turns demand misses into prefetch requests. Each miss arrives with a flag that says whether it was an instruction fetch or a data access. For instruction misses the engine fetches a short run of the lines that follow. For data misses it first waits for a confirmed linear stream before it issues anything. It does this with a table of eight stream entries. Each entry holds the line address it expects to miss next.

A single generator emits at most one line address per cycle into a four-entry request queue. The consumer pops that queue with a valid/ready handshake. The miss input has no back-pressure. If the queue is full, the request the generator produces in that cycle is dropped. A burst never crosses a 4 KB page. A new trigger that arrives while a burst is still running replaces whatever is left of that burst.

Top module: `l2_stream_prefetcher`

## Requirements
- R1: Addresses are handled at line granularity. The low 5 bits of `miss_addr` are ignored. Every `pf_addr` has its low 5 bits at zero and carries a line address in bits 31:5.
- R2: On an instruction miss to line L, the engine requests lines L+1 up to L+`icfg`, where `icfg` is 1, 2 or 3. A value of 0 disables instruction prefetch.
- R3: A data miss produces no request unless its line equals the expected line of a valid stream entry. A data miss that matches no entry allocates an entry whose expected line is L+1. A second miss to L+1 then confirms the stream and triggers a burst that starts at L+2.
- R4: `dcfg` sets the data burst depth: 0 gives 2 lines, 1 gives 4, 2 gives 8, and 3 gives none. A confirm at line L sets the entry's expected line to L+1+depth. A miss at that line confirms the stream again.
- R5: Eight data streams are tracked independently. Each of the eight can be trained and confirmed while the others keep their state.
- R6: When a miss needs a new entry and all eight are valid, the least recently allocated or confirmed entry is replaced. A later miss at the evicted entry's expected line produces no request.
- R7: No request crosses a 4 KB page. A burst stops after the line whose in-page index is 127. A miss to that last line produces no request.
- R8: The request queue holds 4 entries. Requests produced while it is full are dropped, and the miss input is never stalled.
- R9: A request stays valid with a stable `pf_addr` until it is taken. Requests come out in generation order.
- R10: After reset no request is pending and `pf_valid` is low.
- R11: A trigger that arrives while a burst is running replaces the remainder of that burst. Requests already queued are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A demand miss is presented this cycle |
| miss_instr | input | 1 | 1 = instruction miss, 0 = data miss |
| miss_addr | input | 32 | Byte address of the miss |
| icfg | input | 2 | Instruction prefetch line count (0 = off) |
| dcfg | input | 2 | Data burst depth select (0:2, 1:4, 2:8, 3:off) |
| pf_valid | output | 1 | A prefetch request is at the queue head |
| pf_ready | input | 1 | Consumer takes the head request |
| pf_addr | output | 32 | Line-aligned prefetch byte address |

## Verification
The bench uses the default parameters: 32-bit addresses, 32-byte lines, 4 KB pages, eight streams and a four-entry queue. With eight streams, nine distinct bases are enough to force an eviction and to observe the LRU order. With a four-entry queue, an 8-line burst held against a stalled consumer shows dropping after exactly four requests. Miss lines are placed near in-page index 127 so that the page stop truncates both instruction and data bursts.

// File: rtl/l2_stream_prefetcher.sv
module l2_stream_prefetcher #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int STREAMS    = 8,
  parameter int QDEPTH     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          miss_valid,
  input  logic          miss_instr,
  input  logic [AW-1:0] miss_addr,
  input  logic [1:0]    icfg,
  input  logic [1:0]    dcfg,
  output logic          pf_valid,
  input  logic          pf_ready,
  output logic [AW-1:0] pf_addr
);
  localparam int OFS = $clog2(LINE_BYTES);
  localparam int LW  = AW - OFS;
  localparam int PGL = $clog2(PAGE_BYTES) - OFS;
  localparam int SW  = $clog2(STREAMS);
  localparam int QW  = $clog2(QDEPTH);

  wire unused_ofs = ^miss_addr[OFS-1:0];

  function automatic logic page_last(input logic [LW-1:0] l);
    return &l[PGL-1:0];
  endfunction

  wire [LW-1:0] mline = miss_addr[AW-1:OFS];
  wire          dmiss = miss_valid & ~miss_instr;

  logic [STREAMS-1:0] sv;
  logic [LW-1:0]      sexp [STREAMS];
  logic [SW-1:0]      sage [STREAMS];

  logic          hit, rep;
  logic [SW-1:0] hit_idx, rep_idx, vic, touch_idx;
  logic [3:0]    dburst;

  always_comb begin
    hit = 1'b0; hit_idx = '0;
    rep = 1'b0; rep_idx = '0;
    vic = '0;
    for (int j = STREAMS-1; j >= 0; j--) begin
      if (sv[j] && sexp[j] == mline) begin hit = 1'b1; hit_idx = SW'(j); end
      if (sv[j] && sexp[j] == mline + LW'(1)) begin rep = 1'b1; rep_idx = SW'(j); end
      if (sage[j] == SW'(STREAMS-1)) vic = SW'(j);
    end
    for (int j = STREAMS-1; j >= 0; j--)
      if (!sv[j]) vic = SW'(j);
  end

  assign touch_idx = hit ? hit_idx : (rep ? rep_idx : vic);

  always_comb
    case (dcfg)
      2'd0:    dburst = 4'd2;
      2'd1:    dburst = 4'd4;
      2'd2:    dburst = 4'd8;
      default: dburst = 4'd0;
    endcase

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sv <= '0;
      for (int j = 0; j < STREAMS; j++) begin
        sage[j] <= SW'(j);
        sexp[j] <= '0;
      end
    end else if (dmiss) begin
      if (hit)
        sexp[hit_idx] <= mline + LW'(1) + LW'(dburst);
      else if (!rep) begin
        sv[vic]   <= 1'b1;
        sexp[vic] <= mline + LW'(1);
      end
      for (int j = 0; j < STREAMS; j++) begin
        if (SW'(j) == touch_idx)
          sage[j] <= '0;
        else if (sage[j] < sage[touch_idx])
          sage[j] <= sage[j] + SW'(1);
      end
    end
  end

  wire       i_go    = miss_valid & miss_instr & (icfg != 2'd0) & ~page_last(mline);
  wire       d_go    = dmiss & hit & (dburst != 4'd0) & ~page_last(mline);
  wire       start   = i_go | d_go;
  wire [3:0] start_n = miss_instr ? {2'b00, icfg} : dburst;

  logic          gen_act;
  logic [LW-1:0] gen_line;
  logic [3:0]    gen_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_act  <= 1'b0;
      gen_line <= '0;
      gen_left <= '0;
    end else if (start) begin
      gen_act  <= 1'b1;
      gen_line <= mline + LW'(1);
      gen_left <= start_n;
    end else if (gen_act) begin
      gen_line <= gen_line + LW'(1);
      gen_left <= gen_left - 4'd1;
      if (gen_left == 4'd1 || page_last(gen_line)) gen_act <= 1'b0;
    end
  end

  logic [LW-1:0] q [QDEPTH];
  logic [QW-1:0] wp, rp;
  logic [QW:0]   cnt;

  wire push = gen_act & (cnt != (QW+1)'(QDEPTH));
  wire pop  = pf_valid & pf_ready;

  assign pf_valid = cnt != '0;
  assign pf_addr  = {q[rp], {OFS{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      for (int j = 0; j < QDEPTH; j++) q[j] <= '0;
    end else begin
      if (push) begin
        q[wp] <= gen_line;
        wp    <= wp + QW'(1);
      end
      if (pop) rp <= rp + QW'(1);
      cnt <= cnt + (QW+1)'(push) - (QW+1)'(pop);
    end
  end
endmodule

module l2_stream_prefetcher_chk #(
  parameter int AW = 32, parameter int LW = 27, parameter int PGL = 7,
  parameter int QDEPTH = 4, parameter int QW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          miss_valid,
  input logic          miss_instr,
  input logic [LW-1:0] miss_line,
  input logic [1:0]    icfg,
  input logic          pf_valid,
  input logic          pf_ready,
  input logic [AW-1:0] pf_addr,
  input logic          gen_act,
  input logic [LW-1:0] gen_line,
  input logic [QW:0]   cnt
);
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr)); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (QW+1)'(QDEPTH)); // R8

  AST_PAGE_STAY: assert property (@(posedge clk) disable iff (!rst_n)
    gen_act && !miss_valid |=> !gen_act || gen_line[LW-1:PGL] == $past(gen_line[LW-1:PGL])); // R7

  AST_IPF_START: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && miss_instr && icfg != 2'd0 && !(&miss_line[PGL-1:0])
    |=> gen_act && gen_line == $past(miss_line) + LW'(1)); // R2

  AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_act && !pf_valid && !miss_valid |=> !pf_valid); // R3
endmodule

bind l2_stream_prefetcher l2_stream_prefetcher_chk #(
  .AW(AW), .LW(LW), .PGL(PGL), .QDEPTH(QDEPTH), .QW(QW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_instr(miss_instr),
  .miss_line(mline), .icfg(icfg), .pf_valid(pf_valid), .pf_ready(pf_ready),
  .pf_addr(pf_addr), .gen_act(gen_act), .gen_line(gen_line), .cnt(cnt)
);

// File: tb/sim_l2_stream_prefetcher.sv
`timescale 1ns/1ps
module sim_l2_stream_prefetcher;
  logic        clk = 0, rst_n = 0;
  logic        miss_valid = 0, miss_instr = 0;
  logic [31:0] miss_addr = 0;
  logic [1:0]  icfg = 0, dcfg = 0;
  logic        pf_valid, pf_ready = 1;
  logic [31:0] pf_addr;

  always #2 clk = ~clk;

  l2_stream_prefetcher u0 (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_instr(miss_instr),
    .miss_addr(miss_addr), .icfg(icfg), .dcfg(dcfg), .pf_valid(pf_valid),
    .pf_ready(pf_ready), .pf_addr(pf_addr)
  );

  int          n_run = 0, n_fail = 0;
  string       tag = "R10";
  logic [31:0] expq[$];
  bit          done = 0;

  task automatic chk(input bit ok, input string t, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", t, got, exp);
    end
  endtask

  task automatic want(input logic [26:0] line, input int n);
    for (int i = 1; i <= n; i++) begin
      expq.push_back({line + 27'(i), 5'b0});
      if (&(line[6:0] + 7'(i))) break;
    end
  endtask

  task automatic miss(input bit instr, input logic [26:0] line, input logic [4:0] ofs);
    @(negedge clk);
    miss_valid = 1; miss_instr = instr; miss_addr = {line, ofs};
    @(negedge clk);
    miss_valid = 0;
  endtask

  task automatic settle(input string t);
    repeat (14) @(negedge clk);
    chk(expq.size() == 0 && !pf_valid, t, 32'(expq.size()), 0);
  endtask

  always begin
    @(negedge clk); #1;
    if (rst_n && pf_valid && pf_ready) begin
      if (expq.size() == 0)
        chk(0, {tag, " unexpected request"}, pf_addr, 32'hx);
      else
        chk(pf_addr == expq[0], tag, pf_addr, expq[0]);
      if (expq.size() != 0) void'(expq.pop_front());
    end
  end

  function automatic logic [26:0] base(input int k);
    return 27'((k + 16) << 7) | 27'h10;
  endfunction

  initial begin
    logic [26:0] b;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!pf_valid, "R10 reset idle", {31'b0, pf_valid}, 0);

    tag = "R2";
    for (int d = 1; d <= 3; d++) begin
      icfg = 2'(d); b = 27'h0400_010 + 27'(d << 7);
      want(b, d); miss(1, b, 0); settle("R2 instruction run");
    end
    icfg = 0; miss(1, 27'h0500_020, 0); settle("R2 disabled");

    tag = "R1"; icfg = 2;
    b = 27'h0600_030; want(b, 2); miss(1, b, 5'h1F); settle("R1 byte offset ignored");

    tag = "R3"; dcfg = 0; b = 27'h0700_010;
    miss(0, b, 0); settle("R3 first miss quiet");
    want(b + 1, 2); miss(0, b + 1, 0); settle("R3 confirm");
    tag = "R4"; dcfg = 1;
    want(b + 4, 4); miss(0, b + 4, 0); settle("R4 depth 4 reconfirm");
    dcfg = 2; want(b + 9, 8); miss(0, b + 9, 0); settle("R4 depth 8");
    dcfg = 3; miss(0, b + 18, 0); settle("R4 depth off");
    tag = "R3"; dcfg = 0; b = 27'h0800_010;
    miss(0, b, 0); miss(0, b + 2, 0); settle("R3 nonadjacent quiet");

    tag = "R5";
    for (int k = 0; k < 8; k++) miss(0, base(k), 0);
    settle("R5 training quiet");
    for (int k = 0; k < 8; k++) begin
      want(base(k) + 1, 2); miss(0, base(k) + 1, 0); settle("R5 stream confirm");
    end
    tag = "R6";
    miss(0, base(8), 0);
    miss(0, base(0) + 4, 0); settle("R6 evicted entry quiet");
    want(base(2) + 4, 2); miss(0, base(2) + 4, 0); settle("R6 survivor confirm");
    miss(0, base(1) + 4, 0); settle("R6 second eviction quiet");

    tag = "R7"; icfg = 3;
    b = 27'h0900_07D; want(b, 3); miss(1, b, 0); settle("R7 instruction page stop");
    miss(1, 27'h0900_0FF, 0); settle("R7 last line quiet");
    dcfg = 2; b = 27'h0A00_07C;
    miss(0, b, 0); want(b + 1, 8); miss(0, b + 1, 0); settle("R7 data page stop");

    tag = "R8"; dcfg = 2; b = 27'h0B00_010;
    miss(0, b, 0);
    pf_ready = 0;
    want(b + 1, 4); miss(0, b + 1, 0);
    repeat (6) @(negedge clk);
    held = pf_addr;
    repeat (3) @(negedge clk);
    chk(pf_valid && pf_addr == held && held == {b + 27'd2, 5'b0}, "R9 hold while stalled", pf_addr, held);
    pf_ready = 1;
    settle("R8 overflow dropped");

    tag = "R11"; icfg = 3;
    b = 27'h0C00_010;
    expq.push_back({b + 27'd1, 5'b0});
    want(27'h0D00_010, 3);
    @(negedge clk);
    miss_valid = 1; miss_instr = 1; miss_addr = {b, 5'b0};
    @(negedge clk);
    miss_addr = {27'h0D00_010, 5'b0};
    @(negedge clk);
    miss_valid = 0;
    settle("R11 replace remainder");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule